// File: doc/BRIEF.md
# Period-Measuring Tone Validator

This block decides whether a single-bit square wave, already squared up from a telephone line, carries a call-metering tone at the frequency of the selected plan. It counts reference-clock cycles across groups of 32 consecutive tone periods and judges each group against an inclusive window of counts. A mode input picks the limits for the 12 kHz plan or for the 16 kHz plan. Each group ends with a verdict strobe one clock long, which carries a good/bad flag. An active-low follower output tracks the most recent verdict and so forms an envelope of the tone.

The input passes through a synchroniser, and only rising edges are used. If the tone disappears, a watchdog closes the open group as bad. Verdicts therefore keep coming during silence, and a downstream aggregator always sees a steady stream of packets. The count limits and the watchdog lengths are parameters. With the defaults, a 3.579545 MHz reference gives a window of roughly ±2.5 % around nominal.

Top module: `tone_period_validator`

## Requirements
- R1: During and after reset, until the first verdict, `pkt_valid_o` and `pkt_good_o` are 0 and `follow_n_o` is 1.
- R2: The input passes through a chain of SYNC_STAGES flops, and a rising edge is detected on the reference clock. The first edge seen while no group is open starts a group and emits nothing. The 32nd edge after the start closes the group. It raises `pkt_valid_o` for exactly one cycle, on the clock after that edge is processed, and the same edge starts the next group.
- R3: With `sel_12k_i` = 1, the group length L is the number of clocks from the starting edge to the closing edge. The group is good exactly when LO_12 <= L <= HI_12, with both bounds inclusive.
- R4: With `sel_12k_i` = 0, the group is good exactly when LO_16 <= L <= HI_16. The limits follow the mode level present when the group closes.
- R5: If the count since the last group event reaches the watchdog length of the current mode (WDOG_12 or WDOG_16) and no edge arrives in that cycle, a bad verdict is emitted and the group is abandoned. While silence lasts, this repeats every watchdog length.
- R6: An edge that arrives in the same cycle the watchdog would expire takes precedence. An open group is then advanced or closed as a measurement, and an idle block starts a group from that edge.
- R7: `pkt_good_o` is 1 only in a cycle in which `pkt_valid_o` is 1.
- R8: `follow_n_o` goes to 0 one clock after a good verdict and to 1 one clock after a bad verdict, and holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_12k_i | input | 1 | Plan select: 1 = 12 kHz limits, 0 = 16 kHz limits |
| tone_i | input | 1 | Squared tone input, asynchronous to clk_i |
| pkt_valid_o | output | 1 | One-cycle strobe at the end of each group |
| pkt_good_o | output | 1 | Verdict flag, valid with the strobe |
| follow_n_o | output | 1 | Active-low tone follower |

## Verification
The two functions that can land in the same cycle are the closing or advancing rising edge and the watchdog expiry. The bench provokes this by driving a tone whose 32-period group is exactly the 12 kHz watchdog length, so that edges arrive on the cycle the count reaches the limit. A behavioural model with integer counters gives the edge precedence. It is compared on every clock with the strobe, the flag and the follower, so any early abandonment, missing verdict or shifted group boundary shows up in the cycle where it occurs. Inclusive boundary periods on both sides of each window, and silence, are covered in the same run.

// File: rtl/tpv_pkg.sv
package tpv_pkg;
  typedef struct packed {
    logic valid;
    logic good;
  } verdict_t;

  localparam verdict_t VERDICT_NONE = '{valid: 1'b0, good: 1'b0};
endpackage

// File: rtl/tpv_edge_sync.sv
module tpv_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tpv_group_timer.sv
module tpv_group_timer
  import tpv_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int EDGES = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] wdog_i,
  output verdict_t         verdict_o
);
  localparam int EW = (EDGES > 2) ? $clog2(EDGES) : 1;
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [EW-1:0]    edges_q;
  logic             armed_q;
  verdict_t         verdict_q;
  logic             in_window;

  assign in_window = (cnt_q >= lo_i) && (cnt_q <= hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      edges_q   <= '0;
      armed_q   <= 1'b0;
      verdict_q <= VERDICT_NONE;
    end else begin
      verdict_q <= VERDICT_NONE;
      if (rise_i) begin
        // edge wins over a coinciding watchdog expiry
        if (armed_q && edges_q == LAST_EDGE) begin
          verdict_q <= '{valid: 1'b1, good: in_window};
          edges_q   <= '0;
          cnt_q     <= ONE;
        end else if (armed_q) begin
          edges_q <= edges_q + EW'(1);
          cnt_q   <= cnt_q + ONE;
        end else begin
          armed_q <= 1'b1;
          edges_q <= '0;
          cnt_q   <= ONE;
        end
      end else if (cnt_q >= wdog_i) begin
        verdict_q <= '{valid: 1'b1, good: 1'b0};
        armed_q   <= 1'b0;
        edges_q   <= '0;
        cnt_q     <= ONE;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign verdict_o = verdict_q;
endmodule

// File: rtl/tpv_follower.sv
module tpv_follower
  import tpv_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  verdict_t verdict_i,
  output logic     follow_n_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              follow_n_o <= 1'b1;
    else if (verdict_i.valid) follow_n_o <= ~verdict_i.good;
  end
endmodule

// File: rtl/tone_period_validator.sv
module tone_period_validator
  import tpv_pkg::*;
#(
  parameter int CNT_W       = 15,
  parameter int EDGES       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int LO_12       = 9307,
  parameter int HI_12       = 9783,
  parameter int LO_16       = 6980,
  parameter int HI_16       = 7338,
  parameter int WDOG_12     = 14318,
  parameter int WDOG_16     = 10739
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_12k_i,
  input  logic tone_i,
  output logic pkt_valid_o,
  output logic pkt_good_o,
  output logic follow_n_o
);
  localparam logic [CNT_W-1:0] L12 = CNT_W'(LO_12);
  localparam logic [CNT_W-1:0] H12 = CNT_W'(HI_12);
  localparam logic [CNT_W-1:0] L16 = CNT_W'(LO_16);
  localparam logic [CNT_W-1:0] H16 = CNT_W'(HI_16);
  localparam logic [CNT_W-1:0] W12 = CNT_W'(WDOG_12);
  localparam logic [CNT_W-1:0] W16 = CNT_W'(WDOG_16);

  logic             rise;
  logic [CNT_W-1:0] lo, hi, wdog;
  verdict_t         verdict;

  assign lo   = sel_12k_i ? L12 : L16;
  assign hi   = sel_12k_i ? H12 : H16;
  assign wdog = sel_12k_i ? W12 : W16;

  tpv_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (tone_i),
    .rise_o (rise)
  );

  tpv_group_timer #(.CNT_W(CNT_W), .EDGES(EDGES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .lo_i      (lo),
    .hi_i      (hi),
    .wdog_i    (wdog),
    .verdict_o (verdict)
  );

  tpv_follower u_follow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .verdict_i  (verdict),
    .follow_n_o (follow_n_o)
  );

  assign pkt_valid_o = verdict.valid;
  assign pkt_good_o  = verdict.good;
endmodule

// File: rtl/tpv_checker.sv
module tpv_checker #(
  parameter int GAP_MAX = 30000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pkt_valid_o,
  input logic pkt_good_o,
  input logic follow_n_o
);
  int gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap_q <= 0;
    else if (pkt_valid_o) gap_q <= 0;
    else                  gap_q <= gap_q + 1;
  end

  AST_GOOD_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_good_o |-> pkt_valid_o); // R7
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |=> !pkt_valid_o); // R2
  AST_FOLLOW_ON_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_good_o) |=> !follow_n_o); // R8
  AST_FOLLOW_ON_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_good_o) |=> follow_n_o); // R8
  AST_FOLLOW_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_o |=> $stable(follow_n_o)); // R8
  AST_VERDICT_CADENCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= GAP_MAX); // R5
endmodule

bind tone_period_validator tpv_checker #(
  .GAP_MAX(2 * ((WDOG_12 > WDOG_16) ? WDOG_12 : WDOG_16) + 4)
) u_tpv_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pkt_valid_o (pkt_valid_o),
  .pkt_good_o  (pkt_good_o),
  .follow_n_o  (follow_n_o)
);

// File: tb/tone_period_validator_test.sv
module tone_period_validator_test;
  localparam int LO12 = 608, HI12 = 672, W12 = 960;
  localparam int LO16 = 448, HI16 = 512, W16 = 720;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b1, tone = 1'b0;
  logic pkt_valid, pkt_good, follow_n;
  int checks = 0, errors = 0, good_cnt = 0, bad_cnt = 0;
  bit last_good = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  tone_period_validator #(
    .CNT_W(12), .EDGES(32), .SYNC_STAGES(2),
    .LO_12(LO12), .HI_12(HI12), .LO_16(LO16), .HI_16(HI16),
    .WDOG_12(W12), .WDOG_16(W16)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_12k_i(sel), .tone_i(tone),
    .pkt_valid_o(pkt_valid), .pkt_good_o(pkt_good), .follow_n_o(follow_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: integer clock counts between synchronised rising edges
  bit m_s1, m_s2, m_s3, m_armed, m_rise, e_v, e_g, e_fn;
  int m_cnt, m_edges, m_lo, m_hi, m_wd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_armed = 0; m_cnt = 0; m_edges = 0;
      e_v = 0; e_g = 0; e_fn = 1;
    end else begin
      if (e_v) e_fn = !e_g;
      m_rise = m_s2 && !m_s3;
      m_lo = sel ? LO12 : LO16;
      m_hi = sel ? HI12 : HI16;
      m_wd = sel ? W12 : W16;
      e_v = 0; e_g = 0;
      if (m_rise) begin
        if (!m_armed) begin m_armed = 1; m_edges = 0; m_cnt = 1; end
        else begin
          m_edges++;
          if (m_edges == 32) begin
            e_v = 1; e_g = (m_cnt >= m_lo) && (m_cnt <= m_hi);
            m_edges = 0; m_cnt = 1;
          end else m_cnt++;
        end
      end else if (m_cnt >= m_wd) begin
        e_v = 1; e_g = 0; m_armed = 0; m_edges = 0; m_cnt = 1;
      end else m_cnt++;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = tone;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pkt_valid == e_v, "R2 strobe", pkt_valid, e_v);
      chk(pkt_good == e_g, "R7 flag", pkt_good, e_g);
      chk(follow_n == e_fn, "R8 follower", follow_n, e_fn);
      if (pkt_valid) begin
        if (pkt_good) good_cnt++; else bad_cnt++;
        last_good = pkt_good;
      end
    end
  end

  task automatic run_tone(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      tone = 1'b1; repeat (p / 2) @(negedge clk);
      tone = 1'b0; repeat (p - p / 2) @(negedge clk);
    end
  endtask

  task automatic scenario(input int p, input int n, input bit want_good, input string tag);
    good_cnt = 0; bad_cnt = 0;
    run_tone(p, n);
    if (want_good) chk(good_cnt >= 2, tag, good_cnt, 2);
    else           chk(bad_cnt >= 2, tag, bad_cnt, 2);
    chk(last_good == want_good, tag, last_good, want_good);
    chk(follow_n == !want_good, {tag, " R8 end"}, follow_n, !want_good);
  endtask

  initial begin
    #(150000 * 20);
    if (!done) begin
      done = 1'b1; checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pkt_valid == 0 && pkt_good == 0, "R1 strobe in reset", pkt_valid, 0);
    chk(follow_n == 1, "R1 follower in reset", follow_n, 1);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(follow_n == 1, "R1 follower after reset", follow_n, 1);
    sel = 1'b1;
    scenario(20, 100, 1'b1, "R3 nominal 12k");
    scenario(19, 100, 1'b1, "R3 low bound");
    scenario(21, 100, 1'b1, "R3 high bound");
    scenario(18, 100, 1'b0, "R3 below window");
    scenario(20, 100, 1'b1, "R3 recover");
    scenario(22, 100, 1'b0, "R3 above window");
    good_cnt = 0; bad_cnt = 0; tone = 1'b0;
    repeat (2500) @(negedge clk);
    chk(bad_cnt >= 2 && good_cnt == 0, "R5 silence verdicts", bad_cnt, 2);
    chk(follow_n == 1, "R5 follower on silence", follow_n, 1);
    scenario(30, 100, 1'b0, "R6 edge at watchdog");
    sel = 1'b0;
    scenario(15, 100, 1'b1, "R4 nominal 16k");
    scenario(14, 100, 1'b1, "R4 low bound");
    scenario(16, 100, 1'b1, "R4 high bound");
    scenario(13, 100, 1'b0, "R4 below window");
    scenario(17, 100, 1'b0, "R4 above window");
    scenario(20, 100, 1'b0, "R4 12k tone in 16k mode");
    scenario(15, 100, 1'b1, "R4 recover");
    good_cnt = 0; bad_cnt = 0; tone = 1'b0;
    repeat (1800) @(negedge clk);
    chk(bad_cnt >= 2, "R5 silence 16k", bad_cnt, 2);
    chk(follow_n == 1, "R8 release on silence", follow_n, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule